// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block runs the external memory cycles of a small microcontroller core. It handles program fetches, data reads and data writes. The low address byte and the data byte share one 8-bit lane in time. An address latch enable pulse frames the address half of each cycle, so an external latch can hold the low byte. A separate 8-bit lane carries the high address byte. Each cycle is five phases long, and each phase lasts `PH_CLKS` clocks.

The core presents a request: a type, an address, an addressing-width flag for data accesses and write data. It then waits on `busy` and `done`. For a fetch, the block first decides whether the address lies in internal program memory. If it does, the block only signals that decision and runs no bus cycle. The high lane shows the address for fetches and 16-bit data accesses. For 8-bit data accesses and between cycles it shows the high port register, which lets that register page external data memory. At the start of every external cycle the block pulses a request that the low port register be filled with all ones.

Top module: `ext_bus_seq`

## Requirements
- R1: A request with `req_valid` high while `busy` is low is accepted at the clock edge. An accepted request raises `busy` for exactly 5*PH_CLKS clocks. `done` is high in the last of those clocks. Requests presented while `busy` is high are ignored, and so is `req_type` 3.
- R2: `req_type` encodes 0 as fetch, 1 as data read and 2 as data write. A fetch runs externally when `ea_n` is 0, or when `rom_size` is 3, or when the address exceeds the internal limit. The limit is 0x1FFF for `rom_size` 0, 0x3FFF for 1 and 0x7FFF for 2. Otherwise `int_fetch` is high combinationally in the offered cycle and no cycle starts.
- R3: `ale` is high during phase 0 only. The lane drives the low address byte during phases 0 and 1, so the byte is valid and stable when `ale` falls.
- R4: During a fetch, or a data access with `req_wide`=1, `hi_out` carries address bits 15:8 for the whole cycle. During an 8-bit data access and while idle, `hi_out` follows `p2_reg`, including changes made mid-cycle.
- R5: In a write, the lane drives the write data during phases 2 to 4. `wr_n` is low only during phase 3 (PH_CLKS clocks).
- R6: In a fetch or read, the lane is released from phase 2 on. `psen_n` (fetch) or `rd_n` (read) is low during phases 2 and 3 (2*PH_CLKS clocks). `ad_in` is captured in the last clock before the strobe rises, and `rdata` holds that value until the next read or fetch.
- R7: `lo_set` is high for exactly one clock, the first clock of every external cycle.
- R8: The strobes are active low, and at most one is low at a time. After reset the block is idle: strobes high, `ale` low, lane not driven, `rdata` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_type | input | 2 | 0 fetch, 1 read, 2 write, 3 none |
| req_wide | input | 1 | Data access uses 16-bit address |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| ea_n | input | 1 | External access, active low |
| rom_size | input | 2 | Internal program memory size select |
| p2_reg | input | 8 | High port register contents |
| ad_in | input | 8 | Shared lane input |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | Last clock of cycle |
| int_fetch | output | 1 | Offered fetch is internal |
| rdata | output | 8 | Captured read data |
| ad_out | output | 8 | Shared lane output value |
| ad_oe | output | 1 | Shared lane drive enable |
| hi_out | output | 8 | High address lane |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program read strobe |
| rd_n | output | 1 | Data read strobe |
| wr_n | output | 1 | Data write strobe |
| lo_set | output | 1 | Fill low port register with ones |

## Verification
Two events can land on the same clock. One is a change of the high port register while a cycle is running. The other is a new request arriving while the block is busy. The bench flips `p2_reg` in the middle of every cycle and checks that `hi_out` follows it only in 8-bit data mode. It also offers a second request mid-cycle and checks that no further cycle and no `ale` pulse follow `done`.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int PH_CLKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_type,
  input  logic        req_wide,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  input  logic        ea_n,
  input  logic [1:0]  rom_size,
  input  logic [7:0]  p2_reg,
  input  logic [7:0]  ad_in,
  output logic        busy,
  output logic        done,
  output logic        int_fetch,
  output logic [7:0]  rdata,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  output logic [7:0]  hi_out,
  output logic        ale,
  output logic        psen_n,
  output logic        rd_n,
  output logic        wr_n,
  output logic        lo_set
);
  localparam int SW = (PH_CLKS > 1) ? $clog2(PH_CLKS) : 1;
  localparam logic [2:0] LAST_PH = 3'd4;
  localparam logic [1:0] T_FETCH = 2'd0, T_READ = 2'd1, T_WRITE = 2'd2;

  logic          busy_q, wide_q;
  logic [2:0]    ph_q;
  logic [SW-1:0] sub_q;
  logic [1:0]    typ_q;
  logic [15:0]   addr_q;
  logic [7:0]    wd_q, rd_q;

  wire [15:0] lim = (rom_size == 2'd0) ? 16'h1FFF :
                    (rom_size == 2'd1) ? 16'h3FFF : 16'h7FFF;
  wire fetch_ext = !ea_n || (rom_size == 2'd3) || (req_addr > lim);
  wire is_fetch  = (req_type == T_FETCH);
  wire offered   = req_valid && !busy_q && (req_type != 2'd3);
  wire take      = offered && (!is_fetch || fetch_ext);
  wire last_sub  = (sub_q == SW'(PH_CLKS - 1));
  wire is_wr     = (typ_q == T_WRITE);
  wire strobe_ph = busy_q && (ph_q == 3'd2 || ph_q == 3'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      sub_q  <= '0;
      typ_q  <= '0;
      wide_q <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (take) begin
      busy_q <= 1'b1;
      ph_q   <= '0;
      sub_q  <= '0;
      typ_q  <= req_type;
      wide_q <= req_wide || is_fetch;
      addr_q <= req_addr;
      wd_q   <= req_wdata;
    end else if (busy_q) begin
      if (last_sub) begin
        sub_q <= '0;
        if (ph_q == LAST_PH) busy_q <= 1'b0;
        else                 ph_q   <= ph_q + 3'd1;
      end else begin
        sub_q <= sub_q + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else if (busy_q && !is_wr && ph_q == 3'd3 && last_sub) rd_q <= ad_in;
  end

  assign busy      = busy_q;
  assign done      = busy_q && ph_q == LAST_PH && last_sub;
  assign int_fetch = offered && is_fetch && !fetch_ext;
  assign rdata     = rd_q;
  assign ale       = busy_q && ph_q == 3'd0;
  assign lo_set    = ale && sub_q == '0;
  assign ad_oe     = busy_q && (ph_q <= 3'd1 || is_wr);
  assign ad_out    = (ph_q <= 3'd1) ? addr_q[7:0] : wd_q;
  assign hi_out    = (busy_q && wide_q) ? addr_q[15:8] : p2_reg;
  assign psen_n    = !(strobe_ph && typ_q == T_FETCH);
  assign rd_n      = !(strobe_ph && typ_q == T_READ);
  assign wr_n      = !(busy_q && is_wr && ph_q == 3'd3);

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1);
  assert_idle_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (psen_n && rd_n && wr_n && !ale && !ad_oe));
  assert_ale_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (ad_oe && $stable(ad_out)));
  assert_wr_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> ($past(ad_oe) && $stable(ad_out)));
  assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (ad_oe && $stable(ad_out)));
  assert_done_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_lo_set_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lo_set |-> (ale && !$past(busy)));
endmodule

// File: tb/sim_ext_bus_seq.sv
module sim_ext_bus_seq;
  localparam int PH = 2;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_wide = 0, ea_n = 1;
  logic [1:0] req_type = 2'd3, rom_size = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] req_wdata = 0, p2_reg = 8'hA5, ad_in = 0;
  logic busy, done, int_fetch, ad_oe, ale, psen_n, rd_n, wr_n, lo_set;
  logic [7:0] rdata, ad_out, hi_out;
  int errs = 0, chks = 0;
  logic [7:0] last_rd = 0;

  always #2 clk = ~clk;

  ext_bus_seq #(.PH_CLKS(PH)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lim_of(input logic [1:0] rs);
    return (rs == 0) ? 16'h1FFF : (rs == 1) ? 16'h3FFF : 16'h7FFF;
  endfunction

  task automatic run(input logic [1:0] t, input logic w, input logic [15:0] a,
                     input logic [7:0] wd, input bit ext, input bit intrude);
    int n, hi_bad, stb, wr_low, wr_bad, lo_cnt;
    logic [7:0] lat, good;
    logic lat_oe, prev_ale, seen;
    good = a[7:0] ^ a[15:8] ^ 8'h3C;
    @(negedge clk);
    req_valid = 1; req_type = t; req_wide = w; req_addr = a; req_wdata = wd;
    #1;
    chk(int_fetch == (t == 0 && !ext), "R2 int_fetch", int'(int_fetch), int'(t == 0 && !ext));
    @(negedge clk);
    req_valid = 0; req_type = 2'd3;
    chk(busy == ext, "R1/R2 busy after offer", int'(busy), int'(ext));
    if (!ext) return;
    n = 1; hi_bad = 0; stb = 0; wr_low = 0; wr_bad = 0; lo_cnt = 0;
    lat = 0; lat_oe = 0; prev_ale = 0; seen = 0;
    while (1) begin
      if (prev_ale && !ale) begin lat = ad_out; lat_oe = ad_oe; seen = 1; end
      prev_ale = ale;
      if (hi_out != (((t == 0) || w) ? a[15:8] : p2_reg)) hi_bad++;
      if (lo_set) lo_cnt++;
      if (t == 2) begin
        if (!wr_n) begin wr_low++; if (!ad_oe || ad_out != wd) wr_bad++; end
        if (!psen_n || !rd_n) wr_bad++;
      end else begin
        if ((t == 0 ? !psen_n : !rd_n)) begin stb++; if (ad_oe) hi_bad++; end
        if (!wr_n) hi_bad++;
      end
      ad_in = (!psen_n || !rd_n) ? good : 8'h00;
      if (n == 3) p2_reg = ~p2_reg;
      if (n == 4 && intrude) begin req_valid = 1; req_type = 2'd2; req_addr = 16'h1234; end
      if (n == 5) begin req_valid = 0; req_type = 2'd3; end
      if (done || n > 60) break;
      @(negedge clk); n++;
    end
    chk(n == 5 * PH, "R1 cycle length", n, 5 * PH);
    chk(seen && lat_oe && lat == a[7:0], "R3 address at ale fall", int'(lat), int'(a[7:0]));
    chk(hi_bad == 0, "R4/R6 high lane and lane release", hi_bad, 0);
    chk(lo_cnt == 1, "R7 lo_set pulses", lo_cnt, 1);
    if (t == 2) begin
      chk(wr_low == PH, "R5 wr_n low clocks", wr_low, PH);
      chk(wr_bad == 0, "R5 write data on lane", wr_bad, 0);
    end else begin
      chk(stb == 2 * PH, "R6 read strobe clocks", stb, 2 * PH);
      last_rd = good;
    end
    @(negedge clk);
    ad_in = 8'h00;
    chk(!busy && psen_n && rd_n && wr_n && !ad_oe, "R1/R8 idle after done", int'(busy), 0);
    chk(hi_out == p2_reg, "R4 high lane idle", int'(hi_out), int'(p2_reg));
    chk(rdata == last_rd, "R6 rdata", int'(rdata), int'(last_rd));
    if (intrude) begin
      int al = 0;
      for (int k = 0; k < 6; k++) begin if (ale || busy) al++; @(negedge clk); end
      chk(al == 0, "R1 request while busy ignored", al, 0);
    end
  endtask

  initial begin
    #400000;
    errs++; chks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    #1;
    chk(!busy && psen_n && rd_n && wr_n && !ale && !ad_oe && rdata == 0, "R8 reset state", int'(busy), 0);
    chk(hi_out == p2_reg, "R4 reset high lane", int'(hi_out), int'(p2_reg));
    #9 rst_n = 1;
    // R1: type 3 ignored
    @(negedge clk); req_valid = 1; req_type = 2'd3;
    @(negedge clk); req_valid = 0;
    chk(!busy && !ale, "R1 type 3 ignored", int'(busy), 0);
    ea_n = 0;
    for (int t = 0; t < 3; t++)
      for (int w = 0; w < 2; w++)
        for (int i = 0; i < 6; i++) begin
          logic [15:0] a;
          a = 16'(i * 16'h2E5B + t * 16'h0101 + w * 16'h8000);
          run(2'(t), w[0], a, 8'(a[7:0] + 8'h77), 1'b1, (i == 2));
        end
    // R2: fetch decision sweep
    for (int rs = 0; rs < 4; rs++)
      for (int e = 0; e < 2; e++)
        for (int k = 0; k < 4; k++) begin
          logic [15:0] lm, a;
          bit ext;
          lm = lim_of(2'(rs));
          a = (k == 0) ? lm : (k == 1) ? lm + 16'd1 : (k == 2) ? 16'h0000 : 16'hFFFF;
          ea_n = e[0]; rom_size = 2'(rs);
          ext = (e == 0) || (rs == 3) || (a > lm);
          run(2'd0, 1'b0, a, 8'h00, ext, 1'b0);
        end
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule